// File: doc/BRIEF.md
# GPIO Port with Per-Pin Event Triggering

This block is a general-purpose I/O port of up to 32 pins, reached through a simple memory-mapped register interface. Software drives pins through an output data register and a direction register, and samples them through a read-only input data register. Every pin input is brought into the clock domain by a two-flop synchroniser before it is used.

Each pin owns a control word with a 4-bit trigger field. That field selects whether the pin is disabled, requests DMA on an edge, or raises an interrupt on an edge or on a level. Detected events set a per-pin bit in a status register, which software clears by writing ones. Status bits of interrupt-configured pins are ORed into one port interrupt line. Status bits of DMA-configured pins are ORed into one DMA request line.

The register space has two windows. Address bit 8 clear selects the data window and address bit 8 set selects the event window. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset the output, direction, every pin control word and the status register read 0, and `pin_out`, `pin_oe`, `irq` and `dma_req` are low.
- R2: Address 0x000 holds the output data register, driven onto `pin_out`. Address 0x014 holds the direction register, driven onto `pin_oe`, where 1 means output. Both read back what was written.
- R3: Address 0x010 reads the pins through a two-flop synchroniser. A pin change shows up two clock edges later, and writes to this address have no effect.
- R4: The control word of pin n is at 0x100 + 4*n. Its trigger field is bits 19:16, and all other bits read as 0.
- R5: Trigger codes 0x1 and 0x9 set the pin's status bit on a rising edge, 0x2 and 0xA on a falling edge, and 0x3 and 0xB on either edge. The bit becomes visible on the third clock edge after the pin change.
- R6: Code 0x8 sets the status bit while the synchronised pin is low, and code 0xC sets it while the pin is high. While that level persists, a clear does not leave the bit at 0.
- R7: Code 0x0 and every code not listed in R5 or R6 never set the pin's status bit.
- R8: The status register is at 0x1A0. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: When a clear and a new event reach the same status bit in the same cycle, the bit stays set.
- R10: `irq` is the OR of the status bits of pins with codes 0x8 to 0xC. `dma_req` is the OR of the status bits of pins with codes 0x1 to 0x3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Byte address; bit 8 selects the event window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Port interrupt |
| dma_req | output | 1 | Port DMA request |

## Verification
The bench builds the port with the default of 32 pins, so the full address decode and every status bit position are reachable. It sweeps all sixteen trigger codes, placing each one on a different pin. For each code it drives a low level, a rising edge, a high level and a falling edge, and computes the expected status, `irq` and `dma_req` from the code's bits. It also times the synchroniser latency, the same-cycle clear collision and the write-zero case of the status register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 9;
    localparam int TRIG_LSB = 16;

    localparam logic [7:0] OFS_OUT  = 8'h00;
    localparam logic [7:0] OFS_IN   = 8'h10;
    localparam logic [7:0] OFS_DIR  = 8'h14;
    localparam logic [7:0] OFS_STAT = 8'hA0;

    typedef enum logic [3:0] {
        TRIG_OFF  = 4'h0,
        DMA_RISE  = 4'h1,
        DMA_FALL  = 4'h2,
        DMA_BOTH  = 4'h3,
        IRQ_LOW   = 4'h8,
        IRQ_RISE  = 4'h9,
        IRQ_FALL  = 4'hA,
        IRQ_BOTH  = 4'hB,
        IRQ_HIGH  = 4'hC
    } trig_e;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
        logic on_high;
        logic on_low;
        logic to_irq;
        logic to_dma;
    } trig_dec_t;

    function automatic trig_dec_t decode_trig(input logic [3:0] code);
        trig_dec_t d;
        d = '0;
        case (code)
            DMA_RISE: begin d.on_rise = 1'b1; d.to_dma = 1'b1; end
            DMA_FALL: begin d.on_fall = 1'b1; d.to_dma = 1'b1; end
            DMA_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.to_dma = 1'b1; end
            IRQ_LOW:  begin d.on_low  = 1'b1; d.to_irq = 1'b1; end
            IRQ_RISE: begin d.on_rise = 1'b1; d.to_irq = 1'b1; end
            IRQ_FALL: begin d.on_fall = 1'b1; d.to_irq = 1'b1; end
            IRQ_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.to_irq = 1'b1; end
            IRQ_HIGH: begin d.on_high = 1'b1; d.to_irq = 1'b1; end
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_port_evt.sv
module gpio_port_evt
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_s,
    input  logic [3:0] code,
    input  logic       clr,
    output logic       stat,
    output logic       irq_src,
    output logic       dma_src
);
    trig_dec_t dec;
    logic      prev_q;
    logic      stat_q;
    logic      evt;

    assign dec = decode_trig(code);

    // Edge and level detection on the synchronised pin
    assign evt = (dec.on_rise &  pin_s & ~prev_q)
               | (dec.on_fall & ~pin_s &  prev_q)
               | (dec.on_high &  pin_s)
               | (dec.on_low  & ~pin_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            stat_q <= (stat_q & ~clr) | evt;
        end
    end

    assign stat    = stat_q;
    assign irq_src = stat_q & dec.to_irq;
    assign dma_src = stat_q & dec.to_dma;

    assert_clear_takes_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !stat_q);
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        evt |=> stat_q);
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!evt && !clr) |=> $stable(stat_q));
    assert_level_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (dec.on_high && pin_s) |=> stat_q);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [8:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq,
    output logic              dma_req
);
    localparam int WORD_W = 6;

    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [3:0]       trig_q [NPINS];
    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] stat_v;
    logic [NPINS-1:0] irq_v;
    logic [NPINS-1:0] dma_v;
    logic [NPINS-1:0] clr_v;

    logic             evt_win;
    logic [7:0]       ofs;
    logic [WORD_W-1:0] word;
    logic             ctrl_hit;

    assign evt_win  = addr[8];
    assign ofs      = addr[7:0];
    assign word     = ofs[7:2];
    assign ctrl_hit = evt_win && (ofs[1:0] == 2'b00) && (int'(word) < NPINS);

    gpio_port_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    assign clr_v = (wr_en && evt_win && ofs == OFS_STAT) ? wdata[NPINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (wr_en && !evt_win) begin
            if (ofs == OFS_OUT) out_q <= wdata[NPINS-1:0];
            if (ofs == OFS_DIR) dir_q <= wdata[NPINS-1:0];
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                trig_q[i] <= 4'h0;
            else if (wr_en && ctrl_hit && int'(word) == i)
                trig_q[i] <= wdata[TRIG_LSB +: 4];
        end

        gpio_port_evt u_evt (
            .clk     (clk),
            .rst     (rst),
            .pin_s   (pin_s[i]),
            .code    (trig_q[i]),
            .clr     (clr_v[i]),
            .stat    (stat_v[i]),
            .irq_src (irq_v[i]),
            .dma_src (dma_v[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (ctrl_hit) begin
            for (int k = 0; k < NPINS; k++)
                if (int'(word) == k) rdata[TRIG_LSB +: 4] = trig_q[k];
        end else if (evt_win) begin
            if (ofs == OFS_STAT) rdata[NPINS-1:0] = stat_v;
        end else begin
            case (ofs)
                OFS_OUT: rdata[NPINS-1:0] = out_q;
                OFS_IN:  rdata[NPINS-1:0] = pin_s;
                OFS_DIR: rdata[NPINS-1:0] = dir_q;
                default: rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |irq_v;
    assign dma_req = |dma_v;

    assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_v != '0));
    assert_dma_needs_status_R10: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (stat_v != '0));
    assert_write_out_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == {1'b0, OFS_OUT}) |=> (pin_out == $past(wdata[NPINS-1:0])));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int NP = 32;
    localparam logic [8:0] A_OUT  = 9'h000;
    localparam logic [8:0] A_IN   = 9'h010;
    localparam logic [8:0] A_DIR  = 9'h014;
    localparam logic [8:0] A_CTRL = 9'h100;
    localparam logic [8:0] A_STAT = 9'h1A0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [8:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;
    logic          dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port #(.NPINS(NP)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic bit is_irq(input int e); return e >= 8 && e <= 12; endfunction
    function automatic bit is_dma(input int e); return e >= 1 && e <= 3; endfunction
    function automatic bit f_rise(input int e);
        return (is_dma(e) || (e >= 9 && e <= 11)) && e[0];
    endfunction
    function automatic bit f_fall(input int e);
        return (is_dma(e) || (e >= 9 && e <= 11)) && e[1];
    endfunction
    function automatic bit f_low(input int e);  return e == 8;  endfunction
    function automatic bit f_high(input int e); return e == 12; endfunction

    task automatic chk_evt(input string req, input int e, input int p, input bit exp);
        logic [31:0] v;
        rd(A_STAT, v);
        chk(req, v, exp ? (32'h1 << p) : 32'h0);
        chk({req, " irq R10"}, {31'b0, irq}, {31'b0, exp & is_irq(e)});
        chk({req, " dma R10"}, {31'b0, dma_req}, {31'b0, exp & is_dma(e)});
    endtask

    initial begin
        logic [31:0] v;
        bit s0, ex;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        rd(A_OUT, v);  chk("R1 out", v, 0);
        rd(A_DIR, v);  chk("R1 dir", v, 0);
        rd(A_STAT, v); chk("R1 stat", v, 0);
        rd(A_CTRL, v); chk("R1 ctrl0", v, 0);
        rd(A_CTRL + 9'd124, v); chk("R1 ctrl31", v, 0);
        chk("R1 outs", {pin_out, pin_oe}, 64'h0);
        chk("R1 irq/dma", {30'b0, irq, dma_req}, 0);

        // R2 data and direction
        wr(A_OUT, 32'hA5C3_0F96);
        rd(A_OUT, v); chk("R2 out rb", v, 32'hA5C3_0F96);
        chk("R2 pin_out", pin_out, 32'hA5C3_0F96);
        wr(A_DIR, 32'h3C3C_F00F);
        rd(A_DIR, v); chk("R2 dir rb", v, 32'h3C3C_F00F);
        chk("R2 pin_oe", pin_oe, 32'h3C3C_F00F);

        // R3 input latency and read-only
        pin_in = 32'h1234_5678;
        tick(); rd(A_IN, v); chk("R3 after 1 edge", v, 0);
        tick(); rd(A_IN, v); chk("R3 after 2 edges", v, 32'h1234_5678);
        wr(A_IN, 32'hFFFF_FFFF);
        rd(A_IN, v); chk("R3 write ignored", v, 32'h1234_5678);
        chk("R3 out untouched", pin_out, 32'hA5C3_0F96);
        pin_in = '0;
        repeat (4) tick();

        // R4..R8, R10: sweep all codes, each on its own pin
        for (int e = 0; e < 16; e++) begin
            int p;
            p = (e * 5 + 3) % NP;
            wr(A_CTRL + 9'(p * 4), (32'(e) << 16) | 32'hFFF0_FFFF);
            rd(A_CTRL + 9'(p * 4), v); chk("R4 ctrl rb", v, 32'(e) << 16);
            repeat (4) tick();
            wr(A_STAT, 32'hFFFF_FFFF); tick();
            s0 = f_low(e);
            chk_evt("R6/R7 low level", e, p, s0);
            pin_in[p] = 1'b1;
            repeat (4) tick();
            ex = s0 | f_rise(e) | f_high(e);
            chk_evt("R5 rise", e, p, ex);
            if (ex) begin
                wr(A_STAT, ~(32'h1 << p));
                chk_evt("R8 zero write keeps", e, p, 1'b1);
            end
            wr(A_STAT, 32'hFFFF_FFFF); tick();
            chk_evt("R8/R6 clear high", e, p, f_high(e));
            pin_in[p] = 1'b0;
            repeat (4) tick();
            chk_evt("R5 fall", e, p, f_high(e) | f_fall(e) | f_low(e));
            wr(A_STAT, 32'hFFFF_FFFF); tick();
            chk_evt("R8/R6 clear low", e, p, f_low(e));
            wr(A_CTRL + 9'(p * 4), 32'h0);
            repeat (3) tick();
            wr(A_STAT, 32'hFFFF_FFFF);
        end

        // R9 clear collides with a rising-edge event on pin 5
        wr(A_CTRL + 9'd20, 32'h0009_0000);
        wr(A_STAT, 32'hFFFF_FFFF);
        pin_in[5] = 1'b1;
        tick(); tick();
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R9 event wins", v, 32'h20);
        chk("R9 irq", {31'b0, irq}, 1);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R8 later clear", v, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule